// File: doc/BRIEF.md
# Memory Write-Readback Test Sequencer

This block exercises a small static RAM that has an asynchronous write strobe. The strobe is active low, and the RAM commits a write on the strobe's rising edge. After a single-cycle start pulse, the sequencer runs four data patterns in a fixed order. For each pattern it first writes every address from 0 up to the top of the array. It then reads every address back in the same ascending order and compares each word with the value it expects.

The expected word is never stored. It is rebuilt from the pattern number and the current address. All bus timing comes from clock-cycle intervals that are set by parameters:
- address/data set-up before the strobe falls,
- strobe-low width,
- recovery after the strobe rises,
- read access delay before the read data is sampled.

The first mismatch raises a fail flag that stays set. That mismatch's address and read word are also captured. A one-cycle done pulse closes the run.

The controller is a single state machine with six states:
- `ST_IDLE` waits for start. When start arrives it goes to `ST_WR_SETUP` with address 0 and pattern 0.
- `ST_WR_SETUP` holds address and data with the strobe high. When its interval expires it goes to `ST_WR_STROBE`.
- `ST_WR_STROBE` drives the strobe low. When its interval expires it goes to `ST_WR_RECOVER`.
- `ST_WR_RECOVER` holds the bus with the strobe high. When its interval expires it goes to `ST_WR_SETUP` at the next address. At the top address it goes to `ST_RD_ACCESS` at address 0.
- `ST_RD_ACCESS` waits out the access delay and then compares. After that it does one of three things:
  - stays in `ST_RD_ACCESS` for the next address;
  - returns to `ST_WR_SETUP` at address 0 with the next pattern;
  - after the top address of the last pattern, moves to `ST_DONE`.
- `ST_DONE` lasts one cycle and returns to `ST_IDLE`.

Top module: `mem_pattern_tester`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, busy, done and fail are 0 and the strobe is high (1).
- R2: A start pulse seen in idle begins a run. Busy is then high for exactly 4 * 2^AW * (SETUP_CYC + PULSE_CYC + RECOV_CYC + ACCESS_CYC) cycles.
- R3: Before each strobe fall, address and write data stay unchanged, with the strobe high, for at least SETUP_CYC cycles.
- R4: The strobe stays low for exactly PULSE_CYC cycles. Address and data do not change while it is low. They then stay unchanged for at least RECOV_CYC cycles after it rises.
- R5: During read passes the strobe stays high, so a run has exactly 4 * 2^AW strobe pulses. Read data is compared after ACCESS_CYC cycles at each address.
- R6: Patterns run in the order 0, 1, 2, 3, and each pattern writes addresses 0 up to 2^AW-1 in ascending order. The pattern values are:
  - 0: all zeros;
  - 1: all ones;
  - 2: even-numbered bits 1 and odd-numbered bits 0 (0x55 for 8 bits);
  - 3: the address, zero-extended or truncated to DW bits.
- R7: A mismatch sets fail. Fail then stays 1 until a start is accepted in idle, which clears it.
- R8: fail_addr and fail_data hold the address and read word of the first mismatch of a run. Later mismatches do not change them.
- R9: Done is high for exactly one cycle after the last comparison, with busy low in that cycle.
- R10: A start pulse while busy is ignored. The run's length, its done pulse and its fail state are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle run request |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_we_n | output | 1 | Read/write strobe, high = read, write committed on rising edge |
| mem_rdata | input | DW | RAM read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of first mismatch |
| fail_data | output | DW | Read word at first mismatch |

## Verification
The assertions check the following on every cycle:
- the exact strobe-low width, and that address and data stay held while the strobe is low;
- that the strobe stays high outside a run;
- that done lasts one cycle and follows busy;
- that fail is sticky and the captured failure stays stable.

Only the bench scenarios can show the rest. A behavioural RAM with injected stuck-at bits lets them show:
- the pattern order and values;
- the set-up and recovery margins;
- the total run length;
- which mismatch is captured first when two faults exist;
- that a start during a run changes nothing.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_RECOVER,
        ST_RD_ACCESS,
        ST_DONE
    } mpt_state_e;

    localparam int unsigned PAT_W = 2;
    localparam logic [PAT_W-1:0] PAT_LAST = 2'd3;

endpackage

// File: rtl/mpt_interval_timer.sv
module mpt_interval_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/mpt_pattern_gen.sv
module mpt_pattern_gen #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 8
) (
    input  logic [1:0]    pat_sel,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    logic [DW-1:0] alt_word;
    logic [DW-1:0] addr_word;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign alt_word[i] = ((i % 2) == 0);
        if (i < AW) begin : g_addr
            assign addr_word[i] = addr[i];
        end else begin : g_zero
            assign addr_word[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (pat_sel)
            2'd0:    data = '0;
            2'd1:    data = '1;
            2'd2:    data = alt_word;
            default: data = addr_word;
        endcase
    end
endmodule

// File: rtl/mpt_fail_capture.sv
module mpt_fail_capture #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          check,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] expected,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_data
);
    logic mismatch;
    assign mismatch = check && (rdata != expected);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_data <= '0;
        end else if (clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_data <= '0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= addr;
            fail_data <= rdata;
        end
    end
endmodule

// File: rtl/mem_pattern_tester.sv
module mem_pattern_tester
    import mpt_pkg::*;
#(
    parameter int unsigned AW         = 4,
    parameter int unsigned DW         = 8,
    parameter int unsigned SETUP_CYC  = 2,
    parameter int unsigned PULSE_CYC  = 2,
    parameter int unsigned RECOV_CYC  = 1,
    parameter int unsigned ACCESS_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we_n,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_data
);
    localparam int unsigned MAX_A  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int unsigned MAX_B  = (RECOV_CYC > ACCESS_CYC) ? RECOV_CYC : ACCESS_CYC;
    localparam int unsigned MAX_IV = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W  = (MAX_IV > 1) ? $clog2(MAX_IV) : 1;

    localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RECOV  = CNT_W'(RECOV_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(ACCESS_CYC - 1);
    localparam logic [AW-1:0]    ADDR_TOP  = '1;

    mpt_state_e        state_q, state_d;
    logic [AW-1:0]     addr_q, addr_d;
    logic [PAT_W-1:0]  pat_q, pat_d;
    logic              tmr_load, tmr_last, cmp_en, run_clear;
    logic [CNT_W-1:0]  tmr_val;
    logic [DW-1:0]     exp_word;
    logic              we_n_q, busy_q, done_q;

    mpt_interval_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    mpt_pattern_gen #(.AW(AW), .DW(DW)) patgen_i (
        .pat_sel (pat_q),
        .addr    (addr_q),
        .data    (exp_word)
    );

    mpt_fail_capture #(.AW(AW), .DW(DW)) capture_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (run_clear),
        .check     (cmp_en),
        .addr      (addr_q),
        .rdata     (mem_rdata),
        .expected  (exp_word),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_data (fail_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            pat_q   <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            pat_q   <= pat_d;
        end
    end

    // Next-state and sequencing decisions
    always_comb begin
        state_d   = state_q;
        addr_d    = addr_q;
        pat_d     = pat_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        cmp_en    = 1'b0;
        run_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d   = ST_WR_SETUP;
                    addr_d    = '0;
                    pat_d     = '0;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_SETUP;
                    run_clear = 1'b1;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_last) begin
                    state_d  = ST_WR_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                end
            end
            ST_WR_STROBE: begin
                if (tmr_last) begin
                    state_d  = ST_WR_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RECOV;
                end
            end
            ST_WR_RECOVER: begin
                if (tmr_last) begin
                    tmr_load = 1'b1;
                    if (addr_q == ADDR_TOP) begin
                        state_d = ST_RD_ACCESS;
                        addr_d  = '0;
                        tmr_val = LD_ACCESS;
                    end else begin
                        state_d = ST_WR_SETUP;
                        addr_d  = addr_q + 1'b1;
                        tmr_val = LD_SETUP;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_last) begin
                    cmp_en = 1'b1;
                    if (addr_q != ADDR_TOP) begin
                        addr_d   = addr_q + 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = LD_ACCESS;
                    end else if (pat_q != PAT_LAST) begin
                        state_d  = ST_WR_SETUP;
                        addr_d   = '0;
                        pat_d    = pat_q + 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = LD_SETUP;
                    end else begin
                        state_d  = ST_DONE;
                        addr_d   = '0;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Registered outputs, decoded from the next state so they align with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_n_q <= 1'b1;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            we_n_q <= (state_d != ST_WR_STROBE);
            busy_q <= (state_d != ST_IDLE) && (state_d != ST_DONE);
            done_q <= (state_d == ST_DONE);
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = exp_word;
    assign mem_we_n  = we_n_q;
    assign busy      = busy_q;
    assign done      = done_q;
endmodule

// File: rtl/mpt_checker.sv
module mpt_checker #(
    parameter int unsigned AW        = 4,
    parameter int unsigned DW        = 8,
    parameter int unsigned PULSE_CYC = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_we_n,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic [AW-1:0] fail_addr,
    input logic [DW-1:0] fail_data
);
    int unsigned low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= 0;
        end else if (!mem_we_n) begin
            low_cnt <= low_cnt + 1;
        end else begin
            low_cnt <= 0;
        end
    end

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (low_cnt == PULSE_CYC)); // R4

    AST_BUS_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mem_we_n) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R4

    AST_IDLE_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> mem_we_n); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy)); // R9

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail); // R7

    AST_FIRST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && $past(fail)) |-> ($stable(fail_addr) && $stable(fail_data))); // R8
endmodule

bind mem_pattern_tester mpt_checker #(
    .AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we_n  (mem_we_n),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_data (fail_data)
);

// File: tb/mem_pattern_tester_tb_top.sv
`timescale 1ns/1ps
module mem_pattern_tester_tb_top;
    localparam int AW = 4, DW = 8, SETUP = 2, PULSE = 2, RECOV = 1, ACCESS = 2;
    localparam int DEPTH = 16;
    localparam int RUN_CYC = 4 * DEPTH * (SETUP + PULSE + RECOV + ACCESS);

    typedef struct packed {
        logic       f0_en; logic [3:0] f0_a; logic [2:0] f0_b; logic f0_v;
        logic       f1_en; logic [3:0] f1_a; logic [2:0] f1_b; logic f1_v;
        logic       exp_fail; logic [3:0] exp_addr; logic [7:0] exp_data;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 4'd9,  3'd2, 1'b1, 1'b0, 4'd0, 3'd0, 1'b0, 1'b1, 4'd9,  8'h04},
        '{1'b0, 4'd0,  3'd0, 1'b0, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 4'd0,  8'h00},
        '{1'b1, 4'd5,  3'd7, 1'b0, 1'b0, 4'd0, 3'd0, 1'b0, 1'b1, 4'd5,  8'h7F},
        '{1'b1, 4'd9,  3'd2, 1'b1, 1'b1, 4'd3, 3'd0, 1'b0, 1'b1, 4'd9,  8'h04},
        '{1'b1, 4'd0,  3'd0, 1'b1, 1'b0, 4'd0, 3'd0, 1'b0, 1'b1, 4'd0,  8'h01},
        '{1'b1, 4'd15, 3'd7, 1'b0, 1'b0, 4'd0, 3'd0, 1'b0, 1'b1, 4'd15, 8'h7F}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, fail_data;
    logic mem_we_n, busy, done, fail;

    always #5 clk = ~clk;

    mem_pattern_tester #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
                         .RECOV_CYC(RECOV), .ACCESS_CYC(ACCESS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we_n(mem_we_n), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
        .fail_data(fail_data));

    // Behavioural asynchronous RAM with injectable stuck-at bits
    vec_t cur;
    logic [DW-1:0] mem_arr [DEPTH];
    assign mem_rdata = mem_arr[mem_addr];

    function automatic logic [DW-1:0] faulty(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] r = d;
        if (cur.f0_en && a == cur.f0_a) r[cur.f0_b] = cur.f0_v;
        if (cur.f1_en && a == cur.f1_a) r[cur.f1_b] = cur.f1_v;
        return r;
    endfunction

    always @(posedge mem_we_n) if (rst_n) mem_arr[mem_addr] <= faulty(mem_addr, mem_wdata);

    function automatic logic [DW-1:0] pat_val(input int p, input logic [AW-1:0] a);
        case (p)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h55;
            default: return {4'b0000, a};
        endcase
    endfunction

    // Bus monitor, sampled on the falling edge
    int busy_cnt = 0, done_cnt = 0, both_err = 0, fall_cnt = 0, rise_cnt = 0;
    int seq_err = 0, setup_err = 0, width_err = 0, rec_err = 0;
    int wr_idx = 0, stab = 0, low_run = 0, rec_cnt = 0;
    bit rec_active = 0, prev_we_n = 1;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_wdata = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_we_n = 1; low_run = 0; rec_active = 0; stab = 0;
        end else begin
            if (start && !busy) wr_idx = 0;
            if (busy) busy_cnt++;
            if (done) done_cnt++;
            if (done && busy) both_err++;
            if (!mem_we_n) begin
                if (prev_we_n) begin
                    fall_cnt++;
                    if (stab < SETUP) setup_err++;
                end
                low_run++;
            end else if (!prev_we_n) begin
                rise_cnt++;
                if (low_run != PULSE) width_err++;
                if (prev_addr != AW'(wr_idx % DEPTH) ||
                    prev_wdata != pat_val(wr_idx / DEPTH, AW'(wr_idx % DEPTH))) seq_err++;
                wr_idx++;
                low_run = 0; rec_active = 1; rec_cnt = 1; stab = 1;
            end else begin
                if (mem_addr == prev_addr && mem_wdata == prev_wdata) begin
                    stab++;
                    if (rec_active) rec_cnt++;
                end else begin
                    stab = 1;
                    if (rec_active) begin
                        if (rec_cnt < RECOV) rec_err++;
                        rec_active = 0;
                    end
                end
            end
            prev_we_n = mem_we_n; prev_addr = mem_addr; prev_wdata = mem_wdata;
        end
    end

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(input vec_t v, input int inject_at);
        int b0, d0, be0, f0, r0, se0, st0, w0, rc0, n;
        cur = v;
        b0 = busy_cnt; d0 = done_cnt; be0 = both_err; f0 = fall_cnt; r0 = rise_cnt;
        se0 = seq_err; st0 = setup_err; w0 = width_err; rc0 = rec_err;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        check(fail == 1'b0, "R7", "fail cleared by accepted start", int'(fail), 0);
        n = 0;
        while (!done) begin
            @(posedge clk); #1 start = (n == inject_at);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(busy_cnt - b0 == RUN_CYC, "R2", "busy cycles", busy_cnt - b0, RUN_CYC);
        check(rise_cnt - r0 == 4 * DEPTH, "R6", "writes per run", rise_cnt - r0, 4 * DEPTH);
        check(seq_err - se0 == 0, "R6", "write address/pattern errors", seq_err - se0, 0);
        check(fall_cnt - f0 == 4 * DEPTH, "R5", "strobe pulses per run", fall_cnt - f0, 4 * DEPTH);
        check(setup_err - st0 == 0, "R3", "short set-up intervals", setup_err - st0, 0);
        check(width_err - w0 == 0, "R4", "wrong strobe widths", width_err - w0, 0);
        check(rec_err - rc0 == 0, "R4", "short recovery intervals", rec_err - rc0, 0);
        check(done_cnt - d0 == 1, "R9", "done pulses", done_cnt - d0, 1);
        check(both_err - be0 == 0, "R9", "done with busy high", both_err - be0, 0);
        check(fail == v.exp_fail, "R7", "fail flag", int'(fail), int'(v.exp_fail));
        if (v.exp_fail) begin
            check(fail_addr == v.exp_addr, "R8", "first fail address",
                  int'(fail_addr), int'(v.exp_addr));
            check(fail_data == v.exp_data, "R8", "first fail data",
                  int'(fail_data), int'(v.exp_data));
        end
    endtask

    initial begin
        cur = '0;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && fail == 0 && mem_we_n == 1, "R1",
              "outputs in reset", {busy, done, fail, mem_we_n}, 1);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0 && fail == 0 && mem_we_n == 1, "R1",
              "outputs after reset", {busy, done, fail, mem_we_n}, 1);

        for (int i = 0; i < NVEC; i++) run_case(VECS[i], -1);

        // R10: start pulse in the middle of a failing run is ignored
        run_case(VECS[0], 300);

        // R1: reset applied mid-run returns outputs to rest
        cur = VECS[0];
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        repeat (150) @(posedge clk);
        #1 rst_n = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0 && fail == 0 && mem_we_n == 1, "R1",
              "outputs after mid-run reset", {busy, done, fail, mem_we_n}, 1);
        @(posedge clk); #1 rst_n = 1'b1;

        // Clean run after the interrupted one
        run_case(VECS[1], -1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule